// File: doc/BRIEF.md
# Noncacheable Instruction Fetch Unit

This unit supplies the core with a sequential instruction stream when code runs from memory that is not cached. It keeps a fetch pointer and turns it into read transfers on an AHB-Lite bus. Every transfer is 32 bits wide, whether the core is in 32-bit or 16-bit instruction state. The fetched words land in a four-word buffer. The core takes instructions from that buffer over a valid/ready pair. Each instruction comes with its own address.

A level input allows prefetch. With prefetch off, the unit fetches one word at a time, and only once every instruction already fetched has been consumed. With prefetch on, the unit issues a four-beat incrementing burst if all four words fall within one 1 KB region. Near the end of a region it falls back to single transfers, so speculation never runs past the boundary.

A branch strobe loads a new target. The same strobe discards everything buffered and every beat still in flight. In 16-bit state, one fetched word provides two instructions, lower halfword first.

Top module: `nci_fetch`

## Requirements
- R1: A transfer that starts while prefetch is off is a single fetch: HTRANS=NONSEQ (2'b10) and HBURST=SINGLE (3'b000).
- R2: A transfer that starts while prefetch is on is an INCR4 burst (HBURST=3'b011) when address bits [9:2] are at most 252. Otherwise it is a single fetch (3'b000).
- R3: A burst is one NONSEQ beat followed by exactly three SEQ beats (2'b11), back to back, each address 4 above the one before. No NONSEQ appears while burst beats remain.
- R4: Every transfer has HSIZE=3'b010 (32-bit word).
- R5: In 32-bit state, instr_o is the whole word at instr_pc_o, and the next instruction address is 4 higher.
- R6: In 16-bit state, instr_o holds in bits [15:0] the halfword picked by address bit 1: lower half when 0, upper half when 1. Bits [31:16] are zero and the address advances by 2, so a four-word burst yields eight instructions.
- R7: After flush_i, the next instruction delivered is at the target. It is aligned down to 2 bytes in 16-bit state and to 4 bytes in 32-bit state. The next NONSEQ address is the target aligned down to a word, and data from older transfers is never delivered.
- R8: While HREADY is low during a transfer, HTRANS, HADDR and HBURST keep their values.
- R9: A new fetch (NONSEQ) appears only while the buffer is empty, that is while instr_valid_o is low.
- R10: During reset HTRANS is IDLE and instr_valid_o is low. After reset the first fetch is at RESET_ADDR in 32-bit state.
- R11: Read data is captured only in cycles where HREADY is high. Values on HRDATA during wait cycles never reach instr_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Branch strobe; loads pc_i as the new target |
| pc_i | input | ADDR_W | Branch target address |
| thumb_i | input | 1 | Instruction state taken at flush: 1 selects 16-bit instructions |
| pf_en_i | input | 1 | Prefetch enable, sampled when each fetch starts |
| instr_ready_i | input | 1 | Core accepts the current instruction |
| instr_valid_o | output | 1 | An instruction is available |
| instr_o | output | 32 | Instruction; 16-bit instructions are zero-extended |
| instr_pc_o | output | ADDR_W | Address of instr_o |
| htrans_o | output | 2 | AHB transfer type |
| hburst_o | output | 3 | AHB burst type |
| hsize_o | output | 3 | AHB transfer size |
| haddr_o | output | ADDR_W | AHB address |
| hready_i | input | 1 | AHB transfer done / ready |
| hrdata_i | input | 32 | AHB read data |

## Verification
A wrong buffer pointer or a wrong halfword select shows on instr_o or instr_pc_o at the very next instruction handed over. The bench compares every delivered instruction with the word it computes from that address, so such a fault is caught at once. The fetch planner and the beat sequencer are watched on the bus pins in the cycle where each transfer is visible. A bad boundary decision, a dropped or extra SEQ beat, or an address that moves during a wait state is therefore reported at that transfer. A flush that fails to discard stale beats shows up within one burst as a stale word or address on the instruction port.

// File: rtl/nci_pkg.sv
package nci_pkg;
  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } htrans_e;

  typedef enum logic [2:0] {
    BU_SINGLE = 3'b000,
    BU_INCR   = 3'b001,
    BU_WRAP4  = 3'b010,
    BU_INCR4  = 3'b011
  } hburst_e;

  localparam logic [2:0] SIZE_WORD = 3'b010;
  localparam int unsigned BURST_LEN = 4;
  localparam int unsigned INSTR_W = 32;
endpackage

// File: rtl/nci_burst_plan.sv
module nci_burst_plan
  import nci_pkg::*;
#(
  parameter int unsigned ADDR_W       = 32,
  parameter int unsigned REGION_BYTES = 1024
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              pf_en_i,
  output logic              burst_o,
  output logic [ADDR_W-1:0] next_o
);
  localparam int unsigned REGION_LSB   = $clog2(REGION_BYTES);
  localparam int unsigned IDX_W        = REGION_LSB - 2;
  localparam int unsigned REGION_WORDS = REGION_BYTES / 4;
  localparam logic [IDX_W-1:0] LAST_START = IDX_W'(REGION_WORDS - BURST_LEN);

  logic [IDX_W-1:0] word_idx;
  logic             fits;

  assign word_idx = addr_i[REGION_LSB-1:2];
  // all beats stay below the region boundary
  assign fits     = (word_idx <= LAST_START);
  assign burst_o  = pf_en_i & fits;
  assign next_o   = addr_i + (burst_o ? ADDR_W'(4 * BURST_LEN) : ADDR_W'(4));
endmodule

// File: rtl/nci_bus_master.sv
module nci_bus_master
  import nci_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hready_i,
  input  logic              flush_i,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              start_burst_i,
  output logic [1:0]        htrans_o,
  output logic [2:0]        hburst_o,
  output logic [ADDR_W-1:0] haddr_o,
  output logic              capture_o,
  output logic              busy_o
);
  localparam int unsigned BEAT_W = $clog2(BURST_LEN);
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BURST_LEN - 1);

  logic              ap_valid_q, ap_burst_q, ap_keep_q;
  logic [BEAT_W-1:0] beat_q;
  logic [ADDR_W-1:0] addr_q;
  logic              dp_valid_q, dp_keep_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ap_valid_q <= 1'b0;
      ap_burst_q <= 1'b0;
      beat_q     <= '0;
      addr_q     <= '0;
      dp_valid_q <= 1'b0;
    end else if (hready_i) begin
      dp_valid_q <= ap_valid_q;
      if (ap_valid_q) begin
        if (ap_burst_q && beat_q != LAST_BEAT) begin
          beat_q <= beat_q + 1'b1;
          addr_q <= addr_q + ADDR_W'(4);
        end else begin
          ap_valid_q <= 1'b0;
        end
      end else if (start_i) begin
        ap_valid_q <= 1'b1;
        ap_burst_q <= start_burst_i;
        beat_q     <= '0;
        addr_q     <= start_addr_i;
      end
    end
  end

  // keep flags: a flush orphans every beat already issued
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ap_keep_q <= 1'b0;
      dp_keep_q <= 1'b0;
    end else begin
      if (flush_i)                 ap_keep_q <= 1'b0;
      else if (hready_i && start_i) ap_keep_q <= 1'b1;
      if (flush_i)       dp_keep_q <= 1'b0;
      else if (hready_i) dp_keep_q <= ap_valid_q & ap_keep_q;
    end
  end

  always_comb begin
    htrans_o = TR_IDLE;
    if (ap_valid_q) htrans_o = (beat_q == '0) ? TR_NONSEQ : TR_SEQ;
    hburst_o = ap_burst_q ? BU_INCR4 : BU_SINGLE;
  end

  assign haddr_o   = addr_q;
  assign capture_o = hready_i & dp_valid_q & dp_keep_q & ~flush_i;
  assign busy_o    = ap_valid_q | dp_valid_q;
endmodule

// File: rtl/nci_word_buf.sv
module nci_word_buf
  import nci_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               wr_en_i,
  input  logic [INSTR_W-1:0] wr_data_i,
  input  logic               pop_i,
  output logic [INSTR_W-1:0] rd_data_o,
  output logic               empty_o
);
  localparam int unsigned IW = $clog2(DEPTH);
  localparam int unsigned PW = IW + 1;

  logic [INSTR_W-1:0] mem_q [DEPTH];
  logic [PW-1:0]      wr_ptr_q, rd_ptr_q;

  always_ff @(posedge clk_i) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (wr_en_i && wr_ptr_q[IW-1:0] == IW'(i)) mem_q[i] <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else if (clr_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      if (wr_en_i)             wr_ptr_q <= wr_ptr_q + 1'b1;
      if (pop_i && !empty_o)   rd_ptr_q <= rd_ptr_q + 1'b1;
    end
  end

  assign empty_o   = (rd_ptr_q == wr_ptr_q);
  assign rd_data_o = mem_q[rd_ptr_q[IW-1:0]];
endmodule

// File: rtl/nci_fetch.sv
module nci_fetch
  import nci_pkg::*;
#(
  parameter int unsigned    ADDR_W       = 32,
  parameter int unsigned    REGION_BYTES = 1024,
  parameter logic [31:0]    RESET_ADDR   = 32'h0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               flush_i,
  input  logic [ADDR_W-1:0]  pc_i,
  input  logic               thumb_i,
  input  logic               pf_en_i,
  input  logic               instr_ready_i,
  output logic               instr_valid_o,
  output logic [INSTR_W-1:0] instr_o,
  output logic [ADDR_W-1:0]  instr_pc_o,
  output logic [1:0]         htrans_o,
  output logic [2:0]         hburst_o,
  output logic [2:0]         hsize_o,
  output logic [ADDR_W-1:0]  haddr_o,
  input  logic               hready_i,
  input  logic [INSTR_W-1:0] hrdata_i
);
  logic [ADDR_W-1:0]  fetch_q, rd_pc_q, next_addr;
  logic               thumb_q;
  logic               burst, busy, capture, buf_empty, start, fire, pop;
  logic [INSTR_W-1:0] buf_word;
  logic [15:0]        half;
  logic               unused_pc0;

  assign unused_pc0 = pc_i[0];

  nci_burst_plan #(.ADDR_W(ADDR_W), .REGION_BYTES(REGION_BYTES)) u_plan (
    .addr_i  (fetch_q),
    .pf_en_i (pf_en_i),
    .burst_o (burst),
    .next_o  (next_addr)
  );

  nci_bus_master #(.ADDR_W(ADDR_W)) u_bus (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .hready_i      (hready_i),
    .flush_i       (flush_i),
    .start_i       (start),
    .start_addr_i  (fetch_q),
    .start_burst_i (burst),
    .htrans_o      (htrans_o),
    .hburst_o      (hburst_o),
    .haddr_o       (haddr_o),
    .capture_o     (capture),
    .busy_o        (busy)
  );

  nci_word_buf #(.DEPTH(BURST_LEN)) u_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (flush_i | start),
    .wr_en_i   (capture),
    .wr_data_i (hrdata_i),
    .pop_i     (pop),
    .rd_data_o (buf_word),
    .empty_o   (buf_empty)
  );

  // new fetch only when idle, drained and not redirected
  assign start = hready_i & ~busy & buf_empty & ~flush_i;
  assign fire  = instr_valid_o & instr_ready_i & ~flush_i;
  assign pop   = fire & (~thumb_q | rd_pc_q[1]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fetch_q <= ADDR_W'(RESET_ADDR) & ~ADDR_W'(3);
      rd_pc_q <= ADDR_W'(RESET_ADDR) & ~ADDR_W'(3);
      thumb_q <= 1'b0;
    end else if (flush_i) begin
      fetch_q <= {pc_i[ADDR_W-1:2], 2'b00};
      rd_pc_q <= {pc_i[ADDR_W-1:2], pc_i[1] & thumb_i, 1'b0};
      thumb_q <= thumb_i;
    end else begin
      if (start) fetch_q <= next_addr;
      if (fire)  rd_pc_q <= rd_pc_q + (thumb_q ? ADDR_W'(2) : ADDR_W'(4));
    end
  end

  assign half          = rd_pc_q[1] ? buf_word[31:16] : buf_word[15:0];
  assign instr_valid_o = ~buf_empty;
  assign instr_o       = thumb_q ? {16'h0000, half} : buf_word;
  assign instr_pc_o    = rd_pc_q;
  assign hsize_o       = SIZE_WORD;
endmodule

// File: rtl/nci_fetch_chk.sv
module nci_fetch_chk
  import nci_pkg::*;
#(
  parameter int unsigned ADDR_W       = 32,
  parameter int unsigned REGION_BYTES = 1024
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        htrans_i,
  input logic [2:0]        hburst_i,
  input logic [2:0]        hsize_i,
  input logic [ADDR_W-1:0] haddr_i,
  input logic              hready_i,
  input logic              instr_valid_i
);
  localparam int unsigned REGION_LSB   = $clog2(REGION_BYTES);
  localparam int unsigned IDX_W        = REGION_LSB - 2;
  localparam logic [IDX_W-1:0] LAST_START = IDX_W'(REGION_BYTES / 4 - BURST_LEN);

  AST_WORD_SIZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    htrans_i[1] |-> hsize_i == SIZE_WORD); // R4

  AST_WAIT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (htrans_i[1] && !hready_i) |=> ($stable(htrans_i) && $stable(haddr_i) && $stable(hburst_i))); // R8

  AST_SEQ_IN_BURST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    htrans_i == 2'b11 |-> hburst_i == 3'b011); // R3

  AST_SEQ_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (htrans_i == 2'b11 && $past(htrans_i[1] && hready_i)) |-> haddr_i == $past(haddr_i) + ADDR_W'(4)); // R3

  AST_BURST_IN_REGION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (htrans_i == 2'b10 && hburst_i == 3'b011) |-> haddr_i[REGION_LSB-1:2] <= LAST_START); // R2

  AST_ISSUE_WHEN_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    htrans_i == 2'b10 |-> !instr_valid_i); // R9
endmodule

bind nci_fetch nci_fetch_chk #(.ADDR_W(ADDR_W), .REGION_BYTES(REGION_BYTES)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .htrans_i      (htrans_o),
  .hburst_i      (hburst_o),
  .hsize_i       (hsize_o),
  .haddr_i       (haddr_o),
  .hready_i      (hready_i),
  .instr_valid_i (instr_valid_o)
);

// File: tb/nci_fetch_tb_top.sv
module nci_fetch_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0, thumb = 1'b0, pf = 1'b1, ready = 1'b0, hready = 1'b1;
  logic [31:0] pc_in = '0;
  logic        instr_valid;
  logic [31:0] instr, instr_pc, haddr, hrdata;
  logic [1:0]  htrans;
  logic [2:0]  hburst, hsize;
  logic [31:0] dp_addr = '0, nxt_dp = '0;

  int checks = 0, errs = 0;
  bit done = 0;

  // model state
  logic [31:0] exp_pc = '0;
  bit          exp_thumb = 0;
  bit          pend_v = 1;
  logic [31:0] pend_tgt = '0;
  string       pend_req = "R10";
  bit          since_flush = 0;
  bit          held = 0, pf_prev = 1;
  logic [1:0]  p_trans = '0;
  logic [2:0]  p_burst = '0;
  logic [31:0] p_addr = '0, seq_addr = '0;
  int          rem = 0;

  always #4 clk = ~clk;

  function automatic logic [31:0] memw(input logic [31:0] a);
    return {~a[17:2], a[17:2]} ^ 32'h1234_8765;
  endfunction

  function automatic logic [31:0] exp_instr(input logic [31:0] a, input bit t);
    logic [31:0] w = memw({a[31:2], 2'b00});
    if (!t) return w;
    return {16'h0000, a[1] ? w[31:16] : w[15:0]};
  endfunction

  assign hrdata = hready ? memw(dp_addr) : 32'hBAD0_0BAD;

  nci_fetch dut_i (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush), .pc_i(pc_in), .thumb_i(thumb),
    .pf_en_i(pf), .instr_ready_i(ready), .instr_valid_o(instr_valid), .instr_o(instr),
    .instr_pc_o(instr_pc), .htrans_o(htrans), .hburst_o(hburst), .hsize_o(hsize),
    .haddr_o(haddr), .hready_i(hready), .hrdata_i(hrdata)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic monitor();
    bit exp_b;
    if (held)
      chk(htrans == p_trans && haddr == p_addr && hburst == p_burst, "R8", "hold in wait", haddr, p_addr);
    if (htrans[1]) chk(hsize == 3'b010, "R4", "hsize", {29'd0, hsize}, 32'd2);
    if (htrans == 2'b10) begin
      chk(rem == 0, "R3", "NONSEQ inside burst", rem, 0);
      chk(!instr_valid, "R9", "issue with buffer non-empty", {31'd0, instr_valid}, 0);
      if (!held) begin
        exp_b = pf_prev && (haddr[9:2] <= 8'd252);
        if (pf_prev) chk(hburst == (exp_b ? 3'b011 : 3'b000), "R2", "burst type", {29'd0, hburst}, exp_b ? 3 : 0);
        else         chk(hburst == 3'b000, "R1", "single when prefetch off", {29'd0, hburst}, 0);
        if (pend_v) begin
          chk(haddr == pend_tgt, pend_req, "first fetch address", haddr, pend_tgt);
          pend_v = 0;
        end
      end
    end else if (htrans == 2'b11) begin
      chk(rem > 0 && haddr == seq_addr && hburst == 3'b011, "R3", "SEQ beat", haddr, seq_addr);
    end else if (rem > 0) begin
      chk(0, "R3", "burst beat missing", {30'd0, htrans}, 32'd3);
    end
    if (htrans[1] && hready) begin
      nxt_dp = haddr;
      if (htrans == 2'b10) begin
        rem = (hburst == 3'b011) ? 3 : 0;
        seq_addr = haddr + 4;
      end else if (rem > 0) begin
        rem--;
        seq_addr = seq_addr + 4;
      end
    end
    held = htrans[1] && !hready;
    p_trans = htrans; p_addr = haddr; p_burst = hburst;
    // instruction stream
    if (instr_valid && ready && !flush) begin
      chk(instr_pc == exp_pc, since_flush ? "R7" : "R5", "instr address", instr_pc, exp_pc);
      chk(instr == exp_instr(exp_pc, exp_thumb), exp_thumb ? "R6 R11" : "R5 R11",
          "instr data", instr, exp_instr(exp_pc, exp_thumb));
      exp_pc = exp_pc + (exp_thumb ? 2 : 4);
      since_flush = 0;
    end
    if (flush) begin
      exp_thumb = thumb;
      exp_pc = thumb ? {pc_in[31:1], 1'b0} : {pc_in[31:2], 2'b00};
      pend_tgt = {pc_in[31:2], 2'b00};
      pend_v = 1; pend_req = "R7"; since_flush = 1;
    end
    pf_prev = pf;
  endtask

  task automatic cycle(input bit f, input logic [31:0] p, input bit t, input bit pe,
                       input bit rdy, input bit hr);
    @(negedge clk);
    dp_addr = nxt_dp;
    flush = f; pc_in = p; thumb = t; pf = pe; ready = rdy; hready = hr;
    #1;
    monitor();
    @(posedge clk);
  endtask

  task automatic phase(input logic [31:0] tgt, input bit t, input bit pe, input int n,
                       input int rdy_pct, input int hr_pct);
    cycle(1, tgt, t, pe, $urandom_range(0, 99) < rdy_pct, $urandom_range(0, 99) < hr_pct);
    for (int i = 0; i < n; i++)
      cycle(0, tgt, t, pe, $urandom_range(0, 99) < rdy_pct, $urandom_range(0, 99) < hr_pct);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    logic [31:0] tgt;
    seed = $urandom(32'd20240611);
    // R10: reset state
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); #1;
      chk(htrans == 2'b00 && !instr_valid, "R10", "reset idle", {30'd0, htrans}, 0);
    end
    @(negedge clk); rst_n = 1'b1;
    // R10 R5: fetch from reset address, 32-bit bursts
    for (int i = 0; i < 30; i++) cycle(0, '0, 0, 1, 1, 1);
    // R2: burst ending exactly at the boundary, then next region
    phase(32'h0000_03F0, 0, 1, 40, 100, 100);
    // R2 R6: near the boundary in 16-bit state, upper half first
    phase(32'h0000_03F6, 1, 1, 60, 100, 100);
    // R1: prefetch off, 32-bit and 16-bit
    phase(32'h0000_0100, 0, 0, 40, 100, 100);
    phase(32'h0000_0202, 1, 0, 50, 90, 80);
    // R7: flush while a burst is in flight, with wait states
    phase(32'h0000_0200, 0, 1, 3, 0, 100);
    phase(32'h0000_0804, 0, 1, 40, 100, 50);
    // R8 R11: heavy wait states
    phase(32'h0000_0540, 1, 1, 80, 80, 30);
    // mixed random
    for (int k = 0; k < 400; k++) begin
      tgt = ($urandom_range(0, 1) == 1) ? 32'h3E0 + $urandom_range(0, 47) : $urandom_range(0, 4095);
      tgt = tgt + 32'h1000 * $urandom_range(0, 2);
      phase(tgt, $urandom_range(0, 1) == 1, $urandom_range(0, 3) != 0,
            $urandom_range(1, 60), $urandom_range(30, 100), $urandom_range(40, 100));
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule